// File: doc/BRIEF.md
# Stack Push, Pop and Call Unit

This unit owns a stack pointer and carries out the stack micro-operations of a processor: push, pop, call, call-with-link-register, return and the start-up operation that seeds the stack. Each operation is handed over as an opcode, an operand size, a source value, a jump target, the address of the next instruction and, for the link form of call, a destination register number. The unit then issues byte-enabled requests on a 64-bit memory port and reports the popped value, the next program counter and the new stack pointer.

The stack grows toward lower addresses. A push writes at the current pointer and then lowers it by the operand size. A pop raises the pointer by the operand size first and then reads. Mixed with word-sized calls and returns, this leaves the pointer four bytes under the most recent word. Any access whose bytes straddle an 8-byte row of the port is split into two beats. The memory answers a read beat on the cycle that follows it.

Top module: `stk_unit`

## Requirements
- R1: Push (opCode 0) stores the lowest N bytes of srcValue at addresses stackPtr..stackPtr+N-1 and then lowers stackPtr by N. opSize 0, 1, 2, 3 selects N = 1, 2, 4, 8. No byte outside that range changes.
- R2: Pop (opCode 1) first raises stackPtr by N and then reads N bytes from the new stackPtr. popValue is little-endian and zero-extended, and popValid is high in the done cycle.
- R3: Call (opCode 2) pushes retAddr as a 4-byte word, whatever opSize is, and reports pcValid with pcTarget = targetAddr.
- R4: Link call (opCode 3) makes no memory access and leaves stackPtr unchanged. It reports linkValid with linkReg = linkDest and linkValue = retAddr, and pcValid with pcTarget = targetAddr.
- R5: Return (opCode 4) pops a 4-byte word and reports pcValid with pcTarget equal to that word.
- R6: Start-up (opCode 5) sets stackPtr to MEM_BYTES-8, pushes retAddr as a word there (so stackPtr ends at MEM_BYTES-12) and reports pcValid with pcTarget = targetAddr.
- R7: Byte at address A travels on lane A mod 8 of an 8-byte-aligned memAddr. An access that crosses a row boundary takes two beats, lower row first and then memAddr+8. memByteEn marks exactly the lanes touched.
- R8: opReady is high only when idle. An operation is accepted on a clock edge with opValid and opReady both high. opValid while busy is ignored. done is a single-cycle pulse 1 cycle after acceptance for a link call, 3 cycles after for a one-beat access and 4 for a two-beat access.
- R9: After reset, stackPtr is 0, opReady is 1, and done and memValid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opValid | input | 1 | Operation request |
| opReady | output | 1 | Unit idle, request accepted on this edge |
| opCode | input | 3 | 0 push, 1 pop, 2 call, 3 link call, 4 return, 5 start-up |
| opSize | input | 2 | Operand size code: 1, 2, 4 or 8 bytes |
| srcValue | input | 64 | Value to push |
| targetAddr | input | ADDR_W | Jump target |
| retAddr | input | ADDR_W | Address of the next instruction |
| linkDest | input | REG_W | Register number for the link call |
| memValid | output | 1 | Memory beat request |
| memWrite | output | 1 | Beat is a write |
| memAddr | output | ADDR_W | Row address, 8-byte aligned |
| memByteEn | output | 8 | Lane enables |
| memWdata | output | 64 | Write data |
| memRdata | input | 64 | Read data, one cycle after a read beat |
| done | output | 1 | Operation complete pulse |
| popValid | output | 1 | popValue is valid (pop) |
| popValue | output | 64 | Popped operand |
| pcValid | output | 1 | pcTarget is valid |
| pcTarget | output | ADDR_W | Next program counter |
| linkValid | output | 1 | Link write request |
| linkReg | output | REG_W | Link register number |
| linkValue | output | ADDR_W | Link value |
| stackPtr | output | ADDR_W | Current stack pointer |

## Verification
On a split read, the read data for the low row is captured in the same cycle that the high-row beat is issued. An error would swap or drop one half of the value. Unaligned 8-byte and word pops and returns provoke this case. The popped value is judged against a byte-level stack model kept by the bench. The start-up operation also loads the pointer and sets the store address on the same edge, and the bench judges this by the final pointer and the stored bytes.

// File: rtl/stk_pkg.sv
package stk_pkg;
  typedef enum logic [2:0] {
    OP_PUSH  = 3'd0,
    OP_POP   = 3'd1,
    OP_CALL  = 3'd2,
    OP_CALLR = 3'd3,
    OP_RET   = 3'd4,
    OP_CRT0  = 3'd5
  } stkOp_e;

  typedef struct packed {
    logic accept;
    logic issue;
    logic beatHi;
    logic capLo;
    logic capHi;
    logic pushRetire;
    logic pcFromStack;
  } dpCtl_t;

  function automatic logic [3:0] sizeBytes(input logic [1:0] code);
    return 4'd1 << code;
  endfunction
endpackage

// File: rtl/stk_datapath.sv
module stk_datapath
  import stk_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int MEM_BYTES = 1024,
  parameter int REG_W     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [2:0]        opCode,
  input  logic [1:0]        opSize,
  input  logic [63:0]       srcValue,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic [ADDR_W-1:0] retAddr,
  input  logic [REG_W-1:0]  linkDest,
  input  logic [63:0]       memRdata,
  output logic              needHi,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memByteEn,
  output logic [63:0]       memWdata,
  output logic [63:0]       popValue,
  output logic [ADDR_W-1:0] pcTarget,
  output logic [REG_W-1:0]  linkReg,
  output logic [ADDR_W-1:0] linkValue,
  output logic [ADDR_W-1:0] stackPtr
);
  localparam logic [ADDR_W-1:0] CRT_SP   = ADDR_W'(MEM_BYTES - 8);
  localparam logic [ADDR_W-1:0] ROW_STEP = ADDR_W'(8);

  stkOp_e opIn;
  logic        wordForced;
  logic [3:0]  effBytes;
  logic [ADDR_W-1:0] effStep;
  logic [63:0] inMask, inValue;

  assign opIn       = stkOp_e'(opCode);
  assign wordForced = opIn inside {OP_CALL, OP_RET, OP_CRT0};
  assign effBytes   = wordForced ? 4'd4 : sizeBytes(opSize);
  assign effStep    = ADDR_W'(effBytes);
  assign inMask     = (64'd1 << {effBytes, 3'b000}) - 64'd1;
  assign inValue    = (opIn inside {OP_CALL, OP_CALLR, OP_CRT0}) ? 64'(retAddr)
                                                                : (srcValue & inMask);

  logic [ADDR_W-1:0] spQ, addrQ, targetQ;
  logic [3:0]        sizeQ;
  logic [63:0]       valueQ;
  logic [127:0]      bufQ;
  logic [REG_W-1:0]  linkRegQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spQ      <= '0;
      addrQ    <= '0;
      targetQ  <= '0;
      sizeQ    <= 4'd1;
      valueQ   <= '0;
      bufQ     <= '0;
      linkRegQ <= '0;
    end else begin
      if (ctl.accept) begin
        sizeQ    <= effBytes;
        valueQ   <= inValue;
        targetQ  <= targetAddr;
        linkRegQ <= linkDest;
        bufQ     <= '0;
        case (opIn)
          OP_CRT0: begin
            spQ   <= CRT_SP;
            addrQ <= CRT_SP;
          end
          OP_POP, OP_RET: begin
            spQ   <= spQ + effStep;
            addrQ <= spQ + effStep;
          end
          default: addrQ <= spQ;
        endcase
      end
      if (ctl.pushRetire) spQ <= spQ - ADDR_W'(sizeQ);
      if (ctl.capLo) bufQ[63:0]   <= memRdata;
      if (ctl.capHi) bufQ[127:64] <= memRdata;
    end
  end

  logic [2:0]        lane;
  logic [15:0]       laneMask;
  logic [127:0]      laneData;
  logic [ADDR_W-1:0] rowBase;
  logic [63:0]       aligned, outMask;

  assign lane     = addrQ[2:0];
  assign laneMask = ((16'd1 << sizeQ) - 16'd1) << lane;
  assign laneData = {64'd0, valueQ} << {lane, 3'b000};
  assign rowBase  = {addrQ[ADDR_W-1:3], 3'b000};
  assign needHi   = |laneMask[15:8];

  assign memAddr   = ctl.beatHi ? rowBase + ROW_STEP : rowBase;
  assign memByteEn = ctl.beatHi ? laneMask[15:8] : laneMask[7:0];
  assign memWdata  = ctl.beatHi ? laneData[127:64] : laneData[63:0];

  assign aligned  = 64'(bufQ >> {lane, 3'b000});
  assign outMask  = (64'd1 << {sizeQ, 3'b000}) - 64'd1;
  assign popValue = aligned & outMask;

  assign pcTarget  = ctl.pcFromStack ? popValue[ADDR_W-1:0] : targetQ;
  assign linkReg   = linkRegQ;
  assign linkValue = valueQ[ADDR_W-1:0];
  assign stackPtr  = spQ;

  // R7: every issued beat touches at least one lane
  assert_lanes_live_R7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.issue |-> memByteEn != 8'd0);

  // R7: a single-beat access enables exactly its operand size in lanes
  assert_lane_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.issue && !ctl.beatHi && !needHi) |-> $countones(memByteEn) == int'(sizeQ));

  // R2: a pop or return raises the pointer on the accepting edge
  assert_pop_advance_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.accept && (opIn inside {OP_POP, OP_RET})) |=>
      stackPtr == $past(stackPtr) + $past(effStep));
endmodule

// File: rtl/stk_control.sv
module stk_control
  import stk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [2:0] opCode,
  input  logic       needHi,
  output dpCtl_t     ctl,
  output logic       opReady,
  output logic       memValid,
  output logic       memWrite,
  output logic       done,
  output logic       pcValid,
  output logic       popValid,
  output logic       linkValid
);
  typedef enum logic [2:0] {S_IDLE, S_BEAT0, S_BEAT1, S_LAND, S_FIN} state_e;

  state_e state;
  stkOp_e opQ;
  logic   rdLoPend, rdHiPend;
  logic   isWrite, isRead;

  assign isWrite = opQ inside {OP_PUSH, OP_CALL, OP_CRT0};
  assign isRead  = opQ inside {OP_POP, OP_RET};
  assign opReady = (state == S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      opQ      <= OP_PUSH;
      rdLoPend <= 1'b0;
      rdHiPend <= 1'b0;
    end else begin
      rdLoPend <= (state == S_BEAT0) && isRead;
      rdHiPend <= (state == S_BEAT1) && isRead;
      case (state)
        S_IDLE: if (opValid) begin
          opQ   <= stkOp_e'(opCode);
          state <= (stkOp_e'(opCode) == OP_CALLR) ? S_FIN : S_BEAT0;
        end
        S_BEAT0: state <= needHi ? S_BEAT1 : S_LAND;
        S_BEAT1: state <= S_LAND;
        S_LAND:  state <= S_FIN;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl             = '0;
    ctl.accept      = opReady && opValid;
    ctl.issue       = (state == S_BEAT0) || (state == S_BEAT1);
    ctl.beatHi      = (state == S_BEAT1);
    ctl.capLo       = rdLoPend;
    ctl.capHi       = rdHiPend;
    ctl.pushRetire  = (state == S_LAND) && isWrite;
    ctl.pcFromStack = (opQ == OP_RET);
  end

  assign memValid  = ctl.issue;
  assign memWrite  = ctl.issue && isWrite;
  assign done      = (state == S_FIN);
  assign pcValid   = done && (opQ inside {OP_CALL, OP_CALLR, OP_RET, OP_CRT0});
  assign popValid  = done && (opQ == OP_POP);
  assign linkValid = done && (opQ == OP_CALLR);

  // R8: completion is a one-cycle pulse
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: no memory traffic while idle
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    opReady |-> !memValid);

  // R7: the high-row beat always follows the low-row beat
  assert_hi_after_lo_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BEAT1) |-> $past(state) == S_BEAT0);

  // R4: a link call never touches memory
  assert_link_silent_R4: assert property (@(posedge clk) disable iff (!rstN)
    (opQ == OP_CALLR && !opReady) |-> !memValid);
endmodule

// File: rtl/stk_unit.sv
module stk_unit
  import stk_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int MEM_BYTES = 1024,
  parameter int REG_W     = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  output logic              opReady,
  input  logic [2:0]        opCode,
  input  logic [1:0]        opSize,
  input  logic [63:0]       srcValue,
  input  logic [ADDR_W-1:0] targetAddr,
  input  logic [ADDR_W-1:0] retAddr,
  input  logic [REG_W-1:0]  linkDest,
  output logic              memValid,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memByteEn,
  output logic [63:0]       memWdata,
  input  logic [63:0]       memRdata,
  output logic              done,
  output logic              popValid,
  output logic [63:0]       popValue,
  output logic              pcValid,
  output logic [ADDR_W-1:0] pcTarget,
  output logic              linkValid,
  output logic [REG_W-1:0]  linkReg,
  output logic [ADDR_W-1:0] linkValue,
  output logic [ADDR_W-1:0] stackPtr
);
  dpCtl_t ctl;
  logic   needHi;

  stk_control i_control (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .needHi(needHi),
    .ctl(ctl), .opReady(opReady), .memValid(memValid), .memWrite(memWrite),
    .done(done), .pcValid(pcValid), .popValid(popValid), .linkValid(linkValid)
  );

  stk_datapath #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES), .REG_W(REG_W)) i_datapath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .opCode(opCode), .opSize(opSize),
    .srcValue(srcValue), .targetAddr(targetAddr), .retAddr(retAddr),
    .linkDest(linkDest), .memRdata(memRdata), .needHi(needHi), .memAddr(memAddr),
    .memByteEn(memByteEn), .memWdata(memWdata), .popValue(popValue),
    .pcTarget(pcTarget), .linkReg(linkReg), .linkValue(linkValue), .stackPtr(stackPtr)
  );
endmodule

// File: tb/test_stk_unit.sv
module test_stk_unit;
  localparam int MEM = 1024;
  localparam int N_VEC = 15;

  typedef struct packed {
    logic [2:0]  op;
    logic [1:0]  sz;
    logic [63:0] src;
    logic [15:0] tgt;
    logic [15:0] ret;
    logic [4:0]  dst;
  } vec_t;

  localparam vec_t VECS [N_VEC] = '{
    '{3'd5, 2'd0, 64'h0,                  16'h0100, 16'h0004, 5'd0},
    '{3'd0, 2'd3, 64'h1122334455667788,   16'h0,    16'h0,    5'd0},
    '{3'd0, 2'd0, 64'hFFFFFFFFFFFFFFAB,   16'h0,    16'h0,    5'd0},
    '{3'd0, 2'd1, 64'hDEADBEEFCAFE1234,   16'h0,    16'h0,    5'd0},
    '{3'd0, 2'd2, 64'hA5A55A5A0BADF00D,   16'h0,    16'h0,    5'd0},
    '{3'd2, 2'd3, 64'hFFFF,               16'h0200, 16'h0040, 5'd0},
    '{3'd3, 2'd0, 64'h0,                  16'h0300, 16'h0123, 5'd7},
    '{3'd4, 2'd0, 64'h0,                  16'h0,    16'h0,    5'd0},
    '{3'd1, 2'd2, 64'h0,                  16'h0,    16'h0,    5'd0},
    '{3'd1, 2'd1, 64'h0,                  16'h0,    16'h0,    5'd0},
    '{3'd1, 2'd0, 64'h0,                  16'h0,    16'h0,    5'd0},
    '{3'd1, 2'd3, 64'h0,                  16'h0,    16'h0,    5'd0},
    '{3'd1, 2'd2, 64'h0,                  16'h0,    16'h0,    5'd0},
    '{3'd0, 2'd3, 64'h0102030405060708,   16'h0,    16'h0,    5'd0},
    '{3'd1, 2'd3, 64'h0,                  16'h0,    16'h0,    5'd0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic [1:0]  opSize = '0;
  logic [63:0] srcValue = '0;
  logic [15:0] targetAddr = '0, retAddr = '0;
  logic [4:0]  linkDest = '0;
  logic        opReady, memValid, memWrite, done, popValid, pcValid, linkValid;
  logic [15:0] memAddr, pcTarget, linkValue, stackPtr;
  logic [7:0]  memByteEn;
  logic [63:0] memWdata, memRdata, popValue;
  logic [4:0]  linkReg;

  always #2.5 clk = ~clk;

  stk_unit i_stk_unit (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opReady(opReady), .opCode(opCode),
    .opSize(opSize), .srcValue(srcValue), .targetAddr(targetAddr), .retAddr(retAddr),
    .linkDest(linkDest), .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr),
    .memByteEn(memByteEn), .memWdata(memWdata), .memRdata(memRdata), .done(done),
    .popValid(popValid), .popValue(popValue), .pcValid(pcValid), .pcTarget(pcTarget),
    .linkValid(linkValid), .linkReg(linkReg), .linkValue(linkValue), .stackPtr(stackPtr)
  );

  logic [7:0]  mem    [MEM];
  logic [7:0]  refMem [MEM];
  logic [63:0] rdTmp;
  int          beatCnt = 0;
  int          nChk = 0, nFail = 0;
  int          cycles = 0;

  // memory model: writes by lane, read data returned on the following cycle
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (memValid) begin
      beatCnt <= beatCnt + 1;
      for (int k = 0; k < 8; k++) begin
        rdTmp[8*k +: 8] = mem[(int'(memAddr) + k) % MEM];
        if (memWrite && memByteEn[k]) mem[(int'(memAddr) + k) % MEM] <= memWdata[8*k +: 8];
      end
      memRdata <= rdTmp;
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // reference stack model
  logic [15:0] mSp = '0;
  logic [63:0] expPop;
  int          expAddr, expN;
  logic        expSplit;

  task automatic modelOp(input logic [2:0] op, input logic [1:0] sz,
                         input logic [63:0] src, input logic [15:0] ret);
    logic [63:0] val;
    expN = (op == 3'd2 || op == 3'd4 || op == 3'd5) ? 4 : (1 << sz);
    if (op == 3'd5) mSp = 16'(MEM - 8);
    expPop = '0;
    if (op == 3'd0 || op == 3'd2 || op == 3'd5) begin
      expAddr = int'(mSp);
      val = (op == 3'd0) ? src : 64'(ret);
      for (int i = 0; i < expN; i++) refMem[expAddr + i] = val[8*i +: 8];
      mSp = mSp - 16'(expN);
    end else if (op == 3'd1 || op == 3'd4) begin
      mSp = mSp + 16'(expN);
      expAddr = int'(mSp);
      for (int i = 0; i < expN; i++) expPop[8*i +: 8] = refMem[expAddr + i];
    end else begin
      expAddr = int'(mSp);
    end
    expSplit = (op != 3'd3) && ((expAddr % 8) + expN > 8);
  endtask

  function automatic string opTag(input logic [2:0] op);
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic memCompare(input string req);
    int mism = 0;
    for (int i = 0; i < MEM; i++) if (mem[i] !== refMem[i]) mism++;
    chk(req, "R7 memory bytes differing from model", 64'(mism), 64'd0);
  endtask

  task automatic runVec(input vec_t v);
    int lat;
    string tg;
    tg = opTag(v.op);
    modelOp(v.op, v.sz, v.src, v.ret);
    @(negedge clk);
    chk("R8", "opReady before request", 64'(opReady), 64'd1);
    opCode = v.op; opSize = v.sz; srcValue = v.src; targetAddr = v.tgt;
    retAddr = v.ret; linkDest = v.dst; opValid = 1'b1;
    beatCnt = 0;
    @(posedge clk);
    @(negedge clk);
    opValid = 1'b0;
    lat = 1;
    while (!done && lat < 30) begin
      @(negedge clk);
      lat++;
    end
    chk("R8", {tg, " done latency"}, 64'(lat),
        64'((v.op == 3'd3) ? 1 : (expSplit ? 4 : 3)));
    chk((v.op == 3'd3) ? "R4" : "R7", {tg, " beat count"}, 64'(beatCnt),
        64'((v.op == 3'd3) ? 0 : (expSplit ? 2 : 1)));
    chk(tg, "stackPtr", 64'(stackPtr), 64'(mSp));
    chk(tg, "popValid", 64'(popValid), 64'(v.op == 3'd1));
    if (v.op == 3'd1) chk("R2", "popValue", popValue, expPop);
    chk(tg, "pcValid", 64'(pcValid), 64'(v.op inside {3'd2, 3'd3, 3'd4, 3'd5}));
    if (v.op inside {3'd2, 3'd3, 3'd5}) chk(tg, "pcTarget", 64'(pcTarget), 64'(v.tgt));
    if (v.op == 3'd4) chk("R5", "pcTarget from stack", 64'(pcTarget), 64'(expPop[15:0]));
    chk(tg, "linkValid", 64'(linkValid), 64'(v.op == 3'd3));
    if (v.op == 3'd3) begin
      chk("R4", "linkReg", 64'(linkReg), 64'(v.dst));
      chk("R4", "linkValue", 64'(linkValue), 64'(v.ret));
    end
    memCompare(tg);
    @(negedge clk);
    chk("R8", {tg, " done is one cycle"}, 64'(done), 64'd0);
  endtask

  initial begin
    int lat;
    int extra;
    for (int i = 0; i < MEM; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      refMem[i] = 8'(i) ^ 8'h5A;
    end
    memRdata = '0;
    repeat (3) @(negedge clk);
    chk("R9", "stackPtr in reset", 64'(stackPtr), 64'd0);
    chk("R9", "done in reset", 64'(done), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9", "opReady after reset", 64'(opReady), 64'd1);
    chk("R9", "memValid after reset", 64'(memValid), 64'd0);
    chk("R9", "stackPtr after reset", 64'(stackPtr), 64'd0);

    for (int n = 0; n < N_VEC; n++) runVec(VECS[n]);

    // R8: request held high while busy, with a different opcode, is ignored
    modelOp(3'd0, 2'd2, 64'h00000000CAFEF00D, 16'h0);
    @(negedge clk);
    opCode = 3'd0; opSize = 2'd2; srcValue = 64'h00000000CAFEF00D; opValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    opCode = 3'd1;
    chk("R8", "opReady while busy", 64'(opReady), 64'd0);
    lat = 1;
    while (!done && lat < 30) begin
      @(negedge clk);
      lat++;
    end
    opValid = 1'b0;
    chk("R8", "busy-held push stackPtr", 64'(stackPtr), 64'(mSp));
    memCompare("R8");
    extra = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      if (done || memValid) extra++;
    end
    chk("R8", "activity after ignored request", 64'(extra), 64'd0);
    chk("R8", "stackPtr unchanged by ignored pop", 64'(stackPtr), 64'(mSp));

    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    nChk++;
    nFail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end
endmodule